// File: doc/BRIEF.md
# Sound-chip access busy timer

This block sits on the host side of a sound synthesizer and enforces its access timing. The synthesizer has an FM register bank, a PCM register bank and a port to external sample memory. Each kind of host access needs a different recovery time before the chip accepts the next one. The block watches a tagged access strobe and loads a down-counter with the recovery time for that access kind. It shows the resulting busy state in bit 0 of a status byte.

An access that arrives while the counter is still running is a timing violation. The block latches a sticky violation flag and the 3-bit kind of the first offending access. Both stay set until the host pulses a clear input. The early access is still accepted for timing purposes: it restarts the counter with its own wait. Status reads are free at all times. All waits are counted in chip clocks (33.8688 MHz). The header-load wait of roughly 300 µs becomes 10161 clocks.

Top module: `snd_busy_timer`

## Requirements
- R1: `acc_kind_i` encodes the access kind as follows: 0 = FM register write (address or data), 1 = PCM register write (address or data), 2 = sample-memory write, 3 = sample-memory read, 4 = sample header load, 5 = status read, 6 and 7 = reserved. Kinds 0 to 4 are timed.
- R2: A timed access with `acc_valid_i` high at a clock edge makes `status_o[0]` read 1 for exactly W cycles after that edge and 0 afterwards, where W is the wait for its kind.
- R3: The wait is 56 clocks for an FM access and 88 clocks for a PCM access.
- R4: The wait is 28 clocks for a sample-memory write and 38 clocks for a sample-memory read.
- R5: The wait is 10161 clocks for a sample header load.
- R6: A timed access sampled while `status_o[0]` is 1 sets `status_o[1]` (violation) and writes its kind to `status_o[4:2]` on the next cycle.
- R7: A violating access still restarts the wait window with the wait for its own kind.
- R8: While the violation flag is set, it and the code keep their values through later violations. A `viol_clr_i` pulse with no new violation returns both to 0 on the next cycle.
- R9: If a violation and `viol_clr_i` arrive in the same cycle, the flag stays 1 and the code takes the kind of the new access.
- R10: Status reads (kind 5) and reserved kinds (6, 7) never count as violations and leave the wait counter untouched.
- R11: `rst_ni` low clears the counter, the busy bit and the violation flag and code at once (asynchronously). `status_o[7:5]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Chip clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Host access strobe, one per access |
| acc_kind_i | input | 3 | Access kind code (R1) |
| viol_clr_i | input | 1 | Clears the sticky violation flag and code |
| status_o | output | 8 | [0] busy, [1] violation, [4:2] violation kind, [7:5] zero |

## Verification
Two functions can act in the same cycle: a clear request and a new violation. When both land together, the new violation must win and its kind must replace the stored code, whether or not the flag was already set. The bench provokes this directly. It issues an early access with `viol_clr_i` high, both from a clean flag and from a set flag, and it also lets the random clear pulses overlap random early accesses. Each cycle the bench compares the status byte against a model that applies the violation before the clear. A second overlap arises when a new access lands on the last busy cycle. That access must count as a violation and must also reload the counter.

// File: rtl/snd_busy_pkg.sv
package snd_busy_pkg;

  typedef enum logic [2:0] {
    ACC_FM     = 3'd0,
    ACC_PCM    = 3'd1,
    ACC_MEM_WR = 3'd2,
    ACC_MEM_RD = 3'd3,
    ACC_HDR    = 3'd4,
    ACC_STAT   = 3'd5,
    ACC_RSV6   = 3'd6,
    ACC_RSV7   = 3'd7
  } acc_kind_e;

  localparam int KIND_W        = 3;
  localparam int STAT_W        = 8;
  localparam int STAT_BUSY     = 0;
  localparam int STAT_VIOL     = 1;
  localparam int STAT_CODE_LSB = 2;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/snd_wait_lut.sv
module snd_wait_lut
  import snd_busy_pkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int FM_WAIT     = 56,
  parameter int PCM_WAIT    = 88,
  parameter int MEM_WR_WAIT = 28,
  parameter int MEM_RD_WAIT = 38,
  parameter int HDR_WAIT    = 10161
) (
  input  logic [KIND_W-1:0] kind_i,
  output logic              timed_o,
  output logic [CNT_W-1:0]  len_o
);

  always_comb begin
    timed_o = 1'b1;
    len_o   = '0;
    unique case (acc_kind_e'(kind_i))
      ACC_FM:     len_o = CNT_W'(FM_WAIT);
      ACC_PCM:    len_o = CNT_W'(PCM_WAIT);
      ACC_MEM_WR: len_o = CNT_W'(MEM_WR_WAIT);
      ACC_MEM_RD: len_o = CNT_W'(MEM_RD_WAIT);
      ACC_HDR:    len_o = CNT_W'(HDR_WAIT);
      default:    timed_o = 1'b0; // status read and reserved kinds
    endcase
  end

endmodule

// File: rtl/snd_wait_cnt.sv
module snd_wait_cnt #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = (cnt_q != '0);

  // R2
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(len_i));

  // R2
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && busy_o) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R2
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !busy_o) |=> !busy_o);

endmodule

// File: rtl/snd_viol_trk.sv
module snd_viol_trk
  import snd_busy_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic [KIND_W-1:0] code_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      code_o <= '0;
    end else if (evt_i) begin
      flag_o <= 1'b1;
      // first offender is kept unless a clear lands in the same cycle
      if (!flag_o || clr_i) code_o <= kind_i;
    end else if (clr_i) begin
      flag_o <= 1'b0;
      code_o <= '0;
    end
  end

  // R6
  viol_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !flag_o) |=> flag_o && code_o == $past(kind_i));

  // R8
  viol_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o && $stable(code_o));

  // R8
  viol_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt_i) |=> !flag_o && code_o == '0);

  // R9
  clr_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && evt_i) |=> flag_o && code_o == $past(kind_i));

endmodule

// File: rtl/snd_busy_timer.sv
module snd_busy_timer
  import snd_busy_pkg::*;
#(
  parameter int FM_WAIT     = 56,
  parameter int PCM_WAIT    = 88,
  parameter int MEM_WR_WAIT = 28,
  parameter int MEM_RD_WAIT = 38,
  parameter int HDR_WAIT    = 10161
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       acc_valid_i,
  input  logic [2:0] acc_kind_i,
  input  logic       viol_clr_i,
  output logic [7:0] status_o
);

  localparam int MAX_WAIT = max2(max2(max2(FM_WAIT, PCM_WAIT),
                                      max2(MEM_WR_WAIT, MEM_RD_WAIT)), HDR_WAIT);
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  logic              timed;
  logic [CNT_W-1:0]  len;
  logic              load;
  logic              busy;
  logic              viol_evt;
  logic              viol_flag;
  logic [KIND_W-1:0] viol_code;

  snd_wait_lut #(
    .CNT_W      (CNT_W),
    .FM_WAIT    (FM_WAIT),
    .PCM_WAIT   (PCM_WAIT),
    .MEM_WR_WAIT(MEM_WR_WAIT),
    .MEM_RD_WAIT(MEM_RD_WAIT),
    .HDR_WAIT   (HDR_WAIT)
  ) i_lut (
    .kind_i (acc_kind_i),
    .timed_o(timed),
    .len_o  (len)
  );

  assign load     = acc_valid_i && timed;
  assign viol_evt = load && busy;

  snd_wait_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .len_i (len),
    .busy_o(busy)
  );

  snd_viol_trk i_viol (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (viol_evt),
    .kind_i(acc_kind_i),
    .clr_i (viol_clr_i),
    .flag_o(viol_flag),
    .code_o(viol_code)
  );

  always_comb begin
    status_o                                  = '0;
    status_o[STAT_BUSY]                       = busy;
    status_o[STAT_VIOL]                       = viol_flag;
    status_o[STAT_CODE_LSB +: KIND_W]         = viol_code;
  end

  // R10
  untimed_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_kind_i >= 3'd5 && !busy) |=> !busy);

  // R10
  untimed_viol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_kind_i >= 3'd5 && !viol_flag) |=> !viol_flag);

  // R7
  early_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_evt && len != '0) |=> busy);

endmodule

// File: tb/test_snd_busy_timer.sv
`timescale 1ns/1ps
module test_snd_busy_timer;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       acc_valid;
  logic [2:0] acc_kind;
  logic       viol_clr;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int         m_cnt;
  bit         m_flag;
  logic [2:0] m_code;

  always #2.5 clk = ~clk;

  snd_busy_timer i_snd_busy_timer (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .acc_valid_i(acc_valid),
    .acc_kind_i (acc_kind),
    .viol_clr_i (viol_clr),
    .status_o   (status)
  );

  // R1 kind codes: 0 FM, 1 PCM, 2 mem wr, 3 mem rd, 4 header, 5 status, 6/7 reserved
  function automatic int wait_of(input logic [2:0] k);
    case (k)
      3'd0:    return 56;
      3'd1:    return 88;
      3'd2:    return 28;
      3'd3:    return 38;
      3'd4:    return 10161;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] exp_status();
    return {3'b000, m_code, m_flag, (m_cnt != 0)};
  endfunction

  task automatic check(input string tag);
    checks++;
    if (status !== exp_status()) begin
      errors++;
      $display("FAIL %s status_o=%b expected=%b", tag, status, exp_status());
    end
  endtask

  task automatic model_reset();
    m_cnt  = 0;
    m_flag = 1'b0;
    m_code = 3'd0;
  endtask

  // called at a falling edge; checks at the next falling edge
  task automatic tick(input bit v, input logic [2:0] k, input bit c, input string tag);
    bit timed;
    bit evt;
    acc_valid = v;
    acc_kind  = k;
    viol_clr  = c;
    timed = v && (k <= 3'd4);
    evt   = timed && (m_cnt != 0);
    if (evt) begin
      if (!m_flag || c) m_code = k;
      m_flag = 1'b1;
    end else if (c) begin
      m_flag = 1'b0;
      m_code = 3'd0;
    end
    if (timed) m_cnt = wait_of(k);
    else if (m_cnt != 0) m_cnt--;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    viol_clr  = 1'b0;
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(1'b0, 3'd0, 1'b0, tag);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_ni    = 1'b0;
    acc_valid = 1'b0;
    acc_kind  = 3'd0;
    viol_clr  = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R11 reset state");
    rst_ni = 1'b1;

    // window lengths per kind
    tick(1'b1, 3'd0, 1'b0, "R3 FM start");
    idle(60, "R3 FM window");
    tick(1'b1, 3'd1, 1'b0, "R3 PCM start");
    idle(92, "R3 PCM window");
    tick(1'b1, 3'd2, 1'b0, "R4 mem write start");
    idle(32, "R4 mem write window");
    tick(1'b1, 3'd3, 1'b0, "R4 mem read start");
    idle(42, "R4 mem read window");

    // early access flags and reloads
    tick(1'b1, 3'd0, 1'b0, "R6 FM");
    idle(10, "R6 wait");
    tick(1'b1, 3'd2, 1'b0, "R6 early mem write");
    idle(32, "R7 reload window");
    tick(1'b1, 3'd1, 1'b0, "R8 PCM");
    tick(1'b1, 3'd3, 1'b0, "R8 sticky code");
    idle(45, "R8 hold");
    tick(1'b0, 3'd0, 1'b1, "R8 clear");

    // last busy cycle still counts
    tick(1'b1, 3'd2, 1'b0, "R2 mem write");
    idle(27, "R2 tail");
    tick(1'b1, 3'd0, 1'b0, "R6 last busy cycle");
    idle(60, "R7 window");
    tick(1'b1, 3'd0, 1'b1, "R8 clear with access while idle");

    // clear and violation together
    tick(1'b1, 3'd0, 1'b0, "R9 FM");
    idle(3, "R9 wait");
    tick(1'b1, 3'd3, 1'b1, "R9 clear plus violation, flag clean");
    tick(1'b1, 3'd1, 1'b1, "R9 clear plus violation, flag set");
    idle(92, "R9 drain");
    tick(1'b0, 3'd0, 1'b1, "R8 clear");

    // untimed kinds
    tick(1'b1, 3'd0, 1'b0, "R10 FM");
    idle(5, "R10 wait");
    tick(1'b1, 3'd5, 1'b0, "R10 status read while busy");
    tick(1'b1, 3'd6, 1'b0, "R10 reserved 6 while busy");
    tick(1'b1, 3'd7, 1'b0, "R10 reserved 7 while busy");
    idle(55, "R10 window unchanged");
    tick(1'b1, 3'd5, 1'b0, "R10 status read idle");
    tick(1'b1, 3'd7, 1'b0, "R10 reserved idle");

    // header load
    tick(1'b1, 3'd0, 1'b0, "R5 FM");
    tick(1'b1, 3'd4, 1'b0, "R5 early header");
    idle(10165, "R5 header window");
    tick(1'b0, 3'd0, 1'b1, "R8 clear");

    // asynchronous reset in mid-window with flag set
    tick(1'b1, 3'd1, 1'b0, "R11 PCM");
    tick(1'b1, 3'd1, 1'b0, "R11 early");
    idle(5, "R11 wait");
    rst_ni = 1'b0;
    model_reset();
    #1;
    check("R11 async reset");
    @(negedge clk);
    rst_ni = 1'b1;
    check("R11 after release");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit         v;
      bit         c;
      logic [2:0] k;
      v = ($urandom % 12) == 0;
      k = 3'($urandom % 8);
      if (k == 3'd4 && ($urandom % 16) != 0) k = 3'd1;
      c = ($urandom % 30) == 0;
      tick(v, k, c, "R2/R6/R8/R9 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule